// File: doc/BRIEF.md
# Lamp Fault Protection Sequencer

This block supervises a backlight lamp driver. Its inputs are single-bit comparator results: the lamp has no current, the regulation sense is at its limit, the regulation sense is at its arc level, the short-circuit sense is high, the compensation node is high, and the die is over temperature. It also receives one-cycle strobes from the slow burst oscillator and from the fast switching oscillator, together with an enable and an undervoltage flag.

After reset, and each time the driver is re-enabled, the block starts in striking mode. It leaves striking for normal mode at the first burst strobe at which the lamp shows current. Each fault source has its own counter, clocked by oscillator strobes. The count at which a fault trips depends on the mode: slow faults use a long count while striking and a short count in normal mode, while the arc fault is timed on the fast oscillator in either mode. A counter clears as soon as its condition goes away. Every trip sets a shutdown latch. The latch clears only when enable is low or undervoltage is present. While it is set, a hold output pins the burst oscillator at its fault level.

Top module: `lamp_fault_seq`

## Requirements
- R1: After reset, and whenever `en_i` is low or `uvlo_i` is high, `striking_o` reads 1 and `shutdown_o` and `bct_hold_o` read 0.
- R2: In striking mode, a burst strobe sampled while `lamp_off_i` is 0 switches `striking_o` to 0 at that clock edge. Burst strobes sampled while `lamp_off_i` is 1 keep the block in striking mode.
- R3: In striking mode with `lamp_off_i` held at 1, `shutdown_o` rises at the edge that samples the 450th burst strobe, and not before.
- R4: In normal mode with `lamp_off_i` at 1, `shutdown_o` rises at the edge that samples the 3rd burst strobe.
- R5: Each of `short_i`, `comp_hi_i` and `reg_lim_i` has its own burst-strobe counter. The fault trips at the 450th strobe in striking mode or the 32nd strobe in normal mode, counted from when that input rose.
- R6: With `arc_i` at 1, `shutdown_o` rises at the edge that samples the 2nd main-oscillator strobe, in either mode.
- R7: `hot_i` sampled at 1 while the block is enabled sets `shutdown_o` at that same edge.
- R8: Dropping a fault condition for a single cycle clears its counter, so the full count restarts.
- R9: Once set, `shutdown_o` stays at 1 after every fault input is removed. It clears at the edge that samples `en_i` low or `uvlo_i` high.
- R10: `bct_hold_o` is 1 exactly when the shutdown latch is set.
- R11: Main-oscillator strobes do not advance the slow fault counters. The lamp, short, compensation and regulation faults count burst strobes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Driver enable |
| uvlo_i | input | 1 | Supply below the undervoltage level |
| burst_tick_i | input | 1 | One-cycle strobe per burst oscillator period |
| main_tick_i | input | 1 | One-cycle strobe per switching oscillator period |
| lamp_off_i | input | 1 | Lamp current absent (lamp not ignited) |
| reg_lim_i | input | 1 | Regulation sense at its limit |
| arc_i | input | 1 | Regulation sense above the arc level |
| short_i | input | 1 | Short-circuit sense high |
| comp_hi_i | input | 1 | Compensation node high |
| hot_i | input | 1 | Over-temperature |
| shutdown_o | output | 1 | Latched shutdown |
| striking_o | output | 1 | 1 in striking mode, 0 in normal mode |
| bct_hold_o | output | 1 | Forces the burst oscillator to its fault level |

## Verification
Every result is registered once. It appears at the clock edge that samples the strobe completing the count, or the edge that samples the enable or over-temperature change, and no later. The bench drives all inputs on falling edges and holds each strobe for exactly one rising edge. It samples outputs on the next falling edge, so a check lands in the cycle right after the deciding edge. For every timed fault, the bench checks the output both after the strobe one short of the count and after the final strobe, which pins the trip to the exact strobe.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_STRIKE = 1'b1
  } lfs_mode_e;

  // Slow fault sources, each with its own burst-strobe timer
  typedef enum int unsigned {
    SLOW_SHORT = 0,
    SLOW_COMP  = 1,
    SLOW_REG   = 2
  } lfs_slow_e;

  localparam int unsigned N_SLOW = 3;
  // Trip vector: slow faults, lamp timer, arc timer, temperature
  localparam int unsigned N_TRIP = N_SLOW + 3;

endpackage

// File: rtl/lfs_rst_sync.sv
module lfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lfs_tick_timer.sv
module lfs_tick_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cond_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic          cnt_en;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    expire_o = !clr_i && cond_i && tick_i && (cnt_inc >= {1'b0, limit_i});
    cnt_en   = tick_i && (cnt_q != CNT_MAX);
    cnt_d    = cnt_q;
    if (clr_i || !cond_i) cnt_d = '0;
    else if (cnt_en)      cnt_d = cnt_inc[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> (cnt_q == '0)); // R8

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i && !clr_i && !tick_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/lfs_mode_ctrl.sv
module lfs_mode_ctrl
  import lfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic burst_tick_i,
  input  logic lamp_off_i,
  output logic striking_o
);
  lfs_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!active_i)                                   mode_d = MODE_STRIKE;
    else if (mode_q == MODE_STRIKE && burst_tick_i
             && !lamp_off_i)                         mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STRIKE;
    else        mode_q <= mode_d;
  end

  assign striking_o = (mode_q == MODE_STRIKE);

  AST_MODE_ONEWAY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !striking_o) |=> !striking_o); // R2

  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(striking_o) |-> $past(burst_tick_i && !lamp_off_i && active_i)); // R2

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> striking_o); // R1
endmodule

// File: rtl/lfs_fault_latch.sv
module lfs_fault_latch #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic [N-1:0] trip_i,
  output logic         shut_o
);
  logic shut_q, shut_d;

  always_comb begin
    shut_d = shut_q;
    if (!active_i)   shut_d = 1'b0;
    else if (|trip_i) shut_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_q <= 1'b0;
    else        shut_q <= shut_d;
  end

  assign shut_o = shut_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && active_i) |=> shut_q); // R9

  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !shut_q); // R9

  AST_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shut_q) |-> $past(|trip_i)); // R9
endmodule

// File: rtl/lamp_fault_seq.sv
module lamp_fault_seq
  import lfs_pkg::*;
#(
  parameter int unsigned STRIKE_CYC = 450,
  parameter int unsigned NORMAL_CYC = 32,
  parameter int unsigned OPEN_CYC   = 3,
  parameter int unsigned ARC_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic uvlo_i,
  input  logic burst_tick_i,
  input  logic main_tick_i,
  input  logic lamp_off_i,
  input  logic reg_lim_i,
  input  logic arc_i,
  input  logic short_i,
  input  logic comp_hi_i,
  input  logic hot_i,
  output logic shutdown_o,
  output logic striking_o,
  output logic bct_hold_o
);
  localparam int unsigned CW = $clog2(STRIKE_CYC + 1);
  localparam logic [CW-1:0] LIM_STRIKE = CW'(STRIKE_CYC);
  localparam logic [CW-1:0] LIM_NORMAL = CW'(NORMAL_CYC);
  localparam logic [CW-1:0] LIM_OPEN   = CW'(OPEN_CYC);
  localparam logic [CW-1:0] LIM_ARC    = CW'(ARC_CYC);

  logic              rst_s_n;
  logic              active;
  logic              shut;
  logic              striking;
  logic              clr;
  logic [CW-1:0]     slow_lim;
  logic [CW-1:0]     lamp_lim;
  logic [N_SLOW-1:0] slow_cond;
  logic [N_SLOW-1:0] slow_exp;
  logic              lamp_exp;
  logic              arc_exp;
  logic [N_TRIP-1:0] trip;

  lfs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    active   = en_i && !uvlo_i;
    clr      = !active || shut;
    slow_lim = striking ? LIM_STRIKE : LIM_NORMAL;
    lamp_lim = striking ? LIM_STRIKE : LIM_OPEN;
    slow_cond[SLOW_SHORT] = short_i;
    slow_cond[SLOW_COMP]  = comp_hi_i;
    slow_cond[SLOW_REG]   = reg_lim_i;
  end

  lfs_mode_ctrl u_mode (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .active_i     (active),
    .burst_tick_i (burst_tick_i),
    .lamp_off_i   (lamp_off_i),
    .striking_o   (striking)
  );

  // Lamp-absent timer: striking timeout or normal-mode open lamp
  lfs_tick_timer #(.CW(CW)) u_lamp_tmr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr_i    (clr),
    .cond_i   (lamp_off_i),
    .tick_i   (burst_tick_i),
    .limit_i  (lamp_lim),
    .expire_o (lamp_exp)
  );

  for (genvar g = 0; g < N_SLOW; g++) begin : g_slow
    lfs_tick_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .clr_i    (clr),
      .cond_i   (slow_cond[g]),
      .tick_i   (burst_tick_i),
      .limit_i  (slow_lim),
      .expire_o (slow_exp[g])
    );
  end

  lfs_tick_timer #(.CW(CW)) u_arc_tmr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr_i    (clr),
    .cond_i   (arc_i),
    .tick_i   (main_tick_i),
    .limit_i  (LIM_ARC),
    .expire_o (arc_exp)
  );

  assign trip = {hot_i, arc_exp, lamp_exp, slow_exp};

  lfs_fault_latch #(.N(N_TRIP)) u_latch (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .active_i (active),
    .trip_i   (trip),
    .shut_o   (shut)
  );

  assign shutdown_o = shut;
  assign striking_o = striking;
  assign bct_hold_o = shut;

  AST_HOT_TRIP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (active && hot_i) |=> shutdown_o); // R7

  AST_ARC_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(shutdown_o) && !$past(hot_i) && !$past(burst_tick_i)) |-> $past(main_tick_i && arc_i)); // R6

  AST_IDLE_SAFE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !active |=> (!shutdown_o && striking_o)); // R1
endmodule

// File: tb/lamp_fault_seq_tb.sv
module lamp_fault_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, uvlo_i = 1'b0, burst_tick_i = 1'b0, main_tick_i = 1'b0;
  logic lamp_off_i = 1'b1, reg_lim_i = 1'b0, arc_i = 1'b0, short_i = 1'b0;
  logic comp_hi_i = 1'b0, hot_i = 1'b0;
  logic shutdown_o, striking_o, bct_hold_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lamp_fault_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
    .burst_tick_i(burst_tick_i), .main_tick_i(main_tick_i),
    .lamp_off_i(lamp_off_i), .reg_lim_i(reg_lim_i), .arc_i(arc_i),
    .short_i(short_i), .comp_hi_i(comp_hi_i), .hot_i(hot_i),
    .shutdown_o(shutdown_o), .striking_o(striking_o), .bct_hold_o(bct_hold_o)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic bticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) burst_tick_i = 1'b1;
      @(negedge clk) burst_tick_i = 1'b0;
    end
  endtask

  task automatic mticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) main_tick_i = 1'b1;
      @(negedge clk) main_tick_i = 1'b0;
    end
  endtask

  task automatic restart();
    @(negedge clk);
    en_i = 1'b0; uvlo_i = 1'b0; lamp_off_i = 1'b1;
    reg_lim_i = 1'b0; arc_i = 1'b0; short_i = 1'b0; comp_hi_i = 1'b0; hot_i = 1'b0;
    @(negedge clk) en_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic ignite();
    lamp_off_i = 1'b0;
    bticks(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "striking after reset", striking_o, 1'b1);
    check("R1", "shutdown after reset", shutdown_o, 1'b0);
    check("R10", "hold after reset", bct_hold_o, 1'b0);
  endtask

  task automatic t_ignite();
    restart();
    bticks(5);
    check("R2", "still striking while dark", striking_o, 1'b1);
    ignite();
    check("R2", "normal after ignition", striking_o, 1'b0);
    check("R2", "no shutdown on ignition", shutdown_o, 1'b0);
  endtask

  task automatic t_strike_timeout();
    restart();
    bticks(449);
    check("R3", "no trip at 449", shutdown_o, 1'b0);
    bticks(1);
    check("R3", "trip at 450", shutdown_o, 1'b1);
    check("R10", "hold during shutdown", bct_hold_o, 1'b1);
  endtask

  task automatic t_open_normal();
    restart();
    ignite();
    lamp_off_i = 1'b1;
    bticks(2);
    check("R4", "no trip at 2", shutdown_o, 1'b0);
    bticks(1);
    check("R4", "trip at 3", shutdown_o, 1'b1);
  endtask

  task automatic t_slow_normal(int which);
    restart();
    ignite();
    case (which)
      0: short_i = 1'b1;
      1: comp_hi_i = 1'b1;
      default: reg_lim_i = 1'b1;
    endcase
    bticks(31);
    check("R5", "normal slow fault no trip at 31", shutdown_o, 1'b0);
    bticks(1);
    check("R5", "normal slow fault trip at 32", shutdown_o, 1'b1);
  endtask

  task automatic t_slow_strike();
    restart();
    short_i = 1'b1;
    bticks(200);
    @(negedge clk) lamp_off_i = 1'b0;
    @(negedge clk) lamp_off_i = 1'b1;
    bticks(249);
    check("R5", "striking short no trip at 449", shutdown_o, 1'b0);
    check("R5", "still striking", striking_o, 1'b1);
    bticks(1);
    check("R5", "striking short trip at 450", shutdown_o, 1'b1);
  endtask

  task automatic t_independent();
    restart();
    ignite();
    short_i = 1'b1;
    bticks(10);
    reg_lim_i = 1'b1;
    bticks(5);
    short_i = 1'b0;
    bticks(26);
    check("R5", "regulation own count at 31", shutdown_o, 1'b0);
    bticks(1);
    check("R5", "regulation own count at 32", shutdown_o, 1'b1);
  endtask

  task automatic t_clear_on_drop();
    restart();
    ignite();
    comp_hi_i = 1'b1;
    bticks(20);
    @(negedge clk) comp_hi_i = 1'b0;
    @(negedge clk) comp_hi_i = 1'b1;
    bticks(31);
    check("R8", "count restarted, no trip at 31", shutdown_o, 1'b0);
    bticks(1);
    check("R8", "trip at 32 after restart", shutdown_o, 1'b1);
  endtask

  task automatic t_main_ignored();
    restart();
    ignite();
    short_i = 1'b1;
    mticks(40);
    check("R11", "main strobes do not count", shutdown_o, 1'b0);
    bticks(32);
    check("R11", "burst strobes still trip", shutdown_o, 1'b1);
  endtask

  task automatic t_arc(bit normal);
    restart();
    if (normal) ignite();
    arc_i = 1'b1;
    mticks(1);
    check("R6", "no arc trip at 1", shutdown_o, 1'b0);
    mticks(1);
    check("R6", "arc trip at 2", shutdown_o, 1'b1);
    check("R6", "mode unchanged", striking_o, !normal);
  endtask

  task automatic t_latch_en();
    t_arc(1'b1);
    arc_i = 1'b0;
    bticks(5);
    mticks(5);
    check("R9", "latched after fault removed", shutdown_o, 1'b1);
    @(negedge clk) en_i = 1'b0;
    @(negedge clk);
    check("R9", "cleared by enable low", shutdown_o, 1'b0);
    check("R1", "striking while disabled", striking_o, 1'b1);
    check("R10", "hold released", bct_hold_o, 1'b0);
    en_i = 1'b1;
  endtask

  task automatic t_hot_uvlo();
    restart();
    ignite();
    @(negedge clk) hot_i = 1'b1;
    @(negedge clk) hot_i = 1'b0;
    check("R7", "temperature trip next edge", shutdown_o, 1'b1);
    bticks(3);
    check("R9", "temperature trip latched", shutdown_o, 1'b1);
    @(negedge clk) uvlo_i = 1'b1;
    @(negedge clk);
    check("R9", "cleared by undervoltage", shutdown_o, 1'b0);
    check("R1", "striking under undervoltage", striking_o, 1'b1);
    uvlo_i = 1'b0;
    @(negedge clk);
    check("R1", "no shutdown after recovery", shutdown_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en_i = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ignite();
    t_strike_timeout();
    t_open_normal();
    for (int k = 0; k < 3; k++) t_slow_normal(k);
    t_slow_strike();
    t_independent();
    t_clear_on_drop();
    t_main_ignored();
    t_arc(1'b0);
    t_latch_en();
    t_hot_uvlo();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule